// File: doc/BRIEF.md
# Dual 16-bit Interval Timer Pair

This block holds two down-counting interval timers, A and B. Each has a 16-bit reload latch, a 16-bit live counter and an 8-bit control register, all reached over a byte-wide register bus. A timer counts one of several tick sources:

- system clock cycles;
- rising edges on a shared external count input;
- for timer B only, underflows of timer A, either always or only while the count input is high.

When a timer's counter reaches zero and takes one more tick, that is an underflow. The counter reloads from the latch and the timer raises a one-cycle flag for an interrupt collector outside the block. It also drives a port-pin output, which either pulses or toggles, together with an enable that says whether the pin should be driven.

Software loads the latch one byte at a time. It can force a copy of the latch into the counter with a self-clearing strobe bit. It picks continuous or one-shot running. Reading a timer's byte addresses returns the live count.

The external count input passes through a synchronizer of `SYNC_STAGES` flops before edge detection. Count-input events therefore reach the counters `SYNC_STAGES` cycles late.

Top module: `tmr_pair`

## Requirements
- R1: After reset, both latches and both counters hold 0xFFFF, so offsets 4 to 7 read 0xFF. Both control registers read 0x00. The flag and pin outputs are low.
- R2: Latch bytes sit at offsets 4 (timer A low), 5 (timer A high), 6 (timer B low) and 7 (timer B high). Writing a high byte while the timer is stopped also loads the counter with {high byte, latch low byte}. Reads at offsets 4 to 7 return the live counter bytes.
- R3: Writing a high byte while the timer runs changes only the latch, not the counter.
- R4: Control registers sit at offset 14 (A) and offset 15 (B). With bit 0 = 1 (run) and bit 3 = 0 (continuous), a timer with latch L underflows once every L+1 counted ticks and then reloads L.
- R5: With bit 3 = 1 (one-shot), the timer underflows once. Control bit 0 then reads 0 and the counter holds the latch value.
- R6: Control bit 4 is a strobe. Writing 1 copies the latch into the counter. Writing 0 has no effect on the counter. The bit always reads back 0.
- R7: With control bit 0 = 0, the counter holds its value.
- R8: Timer A counts system clock cycles when control bit 5 = 0, and rising edges of `cnt_in` when bit 5 = 1.
- R9: Timer B control bits 6:5 select its tick source: 00 = clock cycles, 01 = `cnt_in` rising edges, 10 = timer A underflows, 11 = timer A underflows while `cnt_in` is high.
- R10: Control bit 1 drives the pin-enable output (`pa_pin_en` for A, `pb_pin_en` for B). With bit 2 = 0, the pin is high for exactly one cycle per underflow.
- R11: With control bit 2 = 1, the pin inverts on every underflow.
- R12: `uf_a_irq` and `uf_b_irq` pulse high for one cycle, in the cycle after each underflowing tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Register access select |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | AW (4) | Register offset |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Read data (zero when not selected) |
| cnt_in | input | 1 | External count input |
| uf_a_irq | output | 1 | Timer A underflow flag pulse |
| uf_b_irq | output | 1 | Timer B underflow flag pulse |
| pa_pin | output | 1 | Timer A port-pin value |
| pa_pin_en | output | 1 | Timer A port-pin drive enable |
| pb_pin | output | 1 | Timer B port-pin value |
| pb_pin_en | output | 1 | Timer B port-pin drive enable |

## Verification
The bench builds the block with its defaults: an 8-bit bus, 16-bit counters, the standard offsets and a two-stage synchronizer. Latches of 1 to 4 make underflows arrive every few cycles. Exact first-underflow cycles, pulse widths, toggle phases and the 3:1 chaining of timer B on timer A therefore fall within a few dozen cycles each. The fixed two-cycle synchronizer latency lets the count-input tests pace their pulses with a known margin and count underflows exactly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // Control register bit positions (shared by both timers)
   localparam int CB_RUN     = 0;
   localparam int CB_PIN_EN  = 1;
   localparam int CB_TOGGLE  = 2;
   localparam int CB_ONESHOT = 3;
   localparam int CB_LOAD    = 4;
   localparam int CB_SRC_LO  = 5;
   localparam int CTL_W      = 8;

   typedef enum logic [1:0] {
      SRC_CLK       = 2'd0,
      SRC_EDGE      = 2'd1,
      SRC_UFA       = 2'd2,
      SRC_UFA_GATED = 2'd3
   } tsrc_e;

   typedef struct packed {
      logic  run;
      logic  pin_en;
      logic  toggle;
      logic  oneshot;
      tsrc_e src;
   } tctl_t;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise
);
   localparam int LAST = STAGES - 1;

   generate
      if (STAGES < 1) begin : g_bad
         $error("tmr_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[LAST:0], din};
   end

   assign level = sh_q[LAST];
   assign rise  = sh_q[LAST] & ~sh_q[STAGES];

endmodule

// File: rtl/tmr_core.sv
module tmr_core
   import tmr_pkg::*;
#(
   parameter int DW   = 8,
   parameter bit IS_B = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_lo,
   input  logic          wr_hi,
   input  logic          wr_ctl,
   input  logic [DW-1:0] wdata,
   input  logic          cnt_lvl,
   input  logic          cnt_rise,
   input  logic          ufa_in,
   output logic [2*DW-1:0] count_o,
   output logic [CTL_W-1:0] ctl_o,
   output logic          uf_o,
   output logic          irq_o,
   output logic          pin_o,
   output logic          pin_en_o
);
   localparam int CW = 2 * DW;

   logic [CW-1:0]    latch_q, count_q;
   logic [CTL_W-1:0] ctl_q;
   logic             irq_q, pls_q, tog_q;
   tctl_t            d;
   logic             tick, uf, force_ld, hi_load, running;

   // Source decode: the variant depends on which timer this is
   generate
      if (IS_B) begin : g_src_b
         assign d.src = tsrc_e'(ctl_q[CB_SRC_LO+1:CB_SRC_LO]);
      end else begin : g_src_a
         assign d.src = ctl_q[CB_SRC_LO] ? SRC_EDGE : SRC_CLK;
      end
   endgenerate

   assign d.run     = ctl_q[CB_RUN];
   assign d.pin_en  = ctl_q[CB_PIN_EN];
   assign d.toggle  = ctl_q[CB_TOGGLE];
   assign d.oneshot = ctl_q[CB_ONESHOT];

   always_comb begin
      case (d.src)
         SRC_CLK:       tick = 1'b1;
         SRC_EDGE:      tick = cnt_rise;
         SRC_UFA:       tick = ufa_in;
         SRC_UFA_GATED: tick = ufa_in & cnt_lvl;
         default:       tick = 1'b0;
      endcase
   end

   assign running  = d.run;
   assign uf       = running && tick && (count_q == '0);
   assign force_ld = wr_ctl && wdata[CB_LOAD];
   assign hi_load  = wr_hi && !running;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '1;
      end else if (wr_lo) begin
         latch_q[DW-1:0] <= wdata;
      end else if (wr_hi) begin
         latch_q[CW-1:DW] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                count_q <= '1;
      else if (force_ld)         count_q <= latch_q;
      else if (hi_load)          count_q <= {wdata, latch_q[DW-1:0]};
      else if (uf)               count_q <= latch_q;
      else if (running && tick)  count_q <= count_q - CW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_ctl) begin
         ctl_q <= wdata[CTL_W-1:0] & ~(CTL_W'(1) << CB_LOAD);
      end else if (uf && d.oneshot) begin
         ctl_q[CB_RUN] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         pls_q <= 1'b0;
         tog_q <= 1'b0;
      end else begin
         irq_q <= uf;
         pls_q <= uf;
         if (uf) tog_q <= ~tog_q;
      end
   end

   assign count_o  = count_q;
   assign ctl_o    = ctl_q;
   assign uf_o     = uf;
   assign irq_o    = irq_q;
   assign pin_o    = d.toggle ? tog_q : pls_q;
   assign pin_en_o = d.pin_en;

   // Strobe: the counter takes the latch value on the next cycle
   assert_force_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      force_ld |=> count_q == $past(latch_q));

   // One-shot: an underflow stops the timer unless software rewrites control
   assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (uf && d.oneshot && !wr_ctl) |=> !ctl_q[CB_RUN]);

   // Stopped timer keeps its count unless a load path fires
   assert_hold_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !force_ld && !wr_hi) |=> $stable(count_q));

   // Underflow reloads the latch value
   assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (uf && !force_ld) |=> count_q == $past(latch_q));

   // Flag follows the underflow by exactly one cycle
   assert_flag_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      uf |=> irq_o);

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
   import tmr_pkg::*;
#(
   parameter int DW          = 8,
   parameter int AW          = 4,
   parameter int OFF_A_LO    = 4,
   parameter int OFF_A_HI    = 5,
   parameter int OFF_B_LO    = 6,
   parameter int OFF_B_HI    = 7,
   parameter int OFF_CTL_A   = 14,
   parameter int OFF_CTL_B   = 15,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_cs,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          cnt_in,
   output logic          uf_a_irq,
   output logic          uf_b_irq,
   output logic          pa_pin,
   output logic          pa_pin_en,
   output logic          pb_pin,
   output logic          pb_pin_en
);
   localparam int CW = 2 * DW;
   localparam int NT = 2;

   generate
      if (DW < CTL_W) begin : g_bad_dw
         $error("tmr_pair: DW must hold a control byte");
      end
      if (OFF_CTL_A >= (1 << AW) || OFF_CTL_B >= (1 << AW)) begin : g_bad_aw
         $error("tmr_pair: offsets exceed address width");
      end
   endgenerate

   logic [NT-1:0]       wr_lo, wr_hi, wr_ctl, uf, irq, pin, pin_en;
   logic [CW-1:0]       cnt_v [NT];
   logic [CTL_W-1:0]    ctl_v [NT];
   logic                cnt_lvl, cnt_rise, unused_b_uf;
   logic                wr;

   assign wr = bus_cs && bus_we;

   tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (cnt_in),
      .level (cnt_lvl),
      .rise  (cnt_rise)
   );

   generate
      for (genvar t = 0; t < NT; t++) begin : g_tmr
         localparam int LO  = (t == 0) ? OFF_A_LO  : OFF_B_LO;
         localparam int HI  = (t == 0) ? OFF_A_HI  : OFF_B_HI;
         localparam int CTL = (t == 0) ? OFF_CTL_A : OFF_CTL_B;
         logic ufa;

         assign wr_lo[t]  = wr && (bus_addr == AW'(LO));
         assign wr_hi[t]  = wr && (bus_addr == AW'(HI));
         assign wr_ctl[t] = wr && (bus_addr == AW'(CTL));

         if (t == 0) begin : g_head
            assign ufa = 1'b0;
         end else begin : g_chain
            assign ufa = uf[t-1];
         end

         tmr_core #(.DW(DW), .IS_B(t == 1)) u_core (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (wr_lo[t]),
            .wr_hi    (wr_hi[t]),
            .wr_ctl   (wr_ctl[t]),
            .wdata    (bus_wdata),
            .cnt_lvl  (cnt_lvl),
            .cnt_rise (cnt_rise),
            .ufa_in   (ufa),
            .count_o  (cnt_v[t]),
            .ctl_o    (ctl_v[t]),
            .uf_o     (uf[t]),
            .irq_o    (irq[t]),
            .pin_o    (pin[t]),
            .pin_en_o (pin_en[t])
         );
      end
   endgenerate

   assign unused_b_uf = uf[NT-1];

   always_comb begin
      bus_rdata = '0;
      if (bus_cs && !bus_we) begin
         if      (bus_addr == AW'(OFF_A_LO))  bus_rdata = cnt_v[0][DW-1:0];
         else if (bus_addr == AW'(OFF_A_HI))  bus_rdata = cnt_v[0][CW-1:DW];
         else if (bus_addr == AW'(OFF_B_LO))  bus_rdata = cnt_v[1][DW-1:0];
         else if (bus_addr == AW'(OFF_B_HI))  bus_rdata = cnt_v[1][CW-1:DW];
         else if (bus_addr == AW'(OFF_CTL_A)) bus_rdata = DW'(ctl_v[0]);
         else if (bus_addr == AW'(OFF_CTL_B)) bus_rdata = DW'(ctl_v[1]);
      end
   end

   assign uf_a_irq  = irq[0];
   assign uf_b_irq  = irq[1];
   assign pa_pin    = pin[0];
   assign pa_pin_en = pin_en[0];
   assign pb_pin    = pin[1];
   assign pb_pin_en = pin_en[1];

   // B in chained mode only ticks together with an A underflow
   assert_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_v[1][6:5] == 2'b10 && ctl_v[1][0] && !uf[0] && !wr_hi[1] && !wr_ctl[1])
         |=> $stable(cnt_v[1]));

endmodule

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;

   localparam int A_LO = 4, A_HI = 5, B_LO = 6, B_HI = 7, CA = 14, CB = 15;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_cs = 1'b0, bus_we = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       cnt_in = 1'b0;
   logic       uf_a_irq, uf_b_irq, pa_pin, pa_pin_en, pb_pin, pb_pin_en;

   int nchk = 0, nfail = 0;
   int na = 0, nb = 0, npa = 0;

   always #4 clk = ~clk;

   tmr_pair u0 (
      .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt_in(cnt_in), .uf_a_irq(uf_a_irq), .uf_b_irq(uf_b_irq),
      .pa_pin(pa_pin), .pa_pin_en(pa_pin_en), .pb_pin(pb_pin), .pb_pin_en(pb_pin_en)
   );

   // Event counters, sampled shortly after each edge
   always @(posedge clk) begin
      #2;
      if (uf_a_irq) na++;
      if (uf_b_irq) nb++;
   end

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_cs = 1'b1; bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = 8'(d);
      @(negedge clk);
      bus_cs = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      bus_cs = 1'b1; bus_we = 1'b0; bus_addr = 4'(a);
      #1 d = int'(bus_rdata);
      bus_cs = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic cnt_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         cnt_in = 1'b1; wait_cyc(3);
         cnt_in = 1'b0; wait_cyc(3);
      end
   endtask

   task automatic t_reset;
      int v;
      for (int a = A_LO; a <= B_HI; a++) begin
         rd(a, v); chk("R1 counter byte", v, 8'hFF);
      end
      rd(CA, v); chk("R1 ctl A", v, 0);
      rd(CB, v); chk("R1 ctl B", v, 0);
      chk("R1 outputs", {uf_a_irq, uf_b_irq, pa_pin, pb_pin, pa_pin_en, pb_pin_en}, 0);
   endtask

   task automatic t_latch_load;
      int v;
      wr(A_LO, 8'h34); wr(A_HI, 8'h12);
      rd(A_LO, v); chk("R2 A low", v, 8'h34);
      rd(A_HI, v); chk("R2 A high", v, 8'h12);
      wr(B_LO, 8'h78); wr(B_HI, 8'h56);
      rd(B_LO, v); chk("R2 B low", v, 8'h78);
      rd(B_HI, v); chk("R2 B high", v, 8'h56);
   endtask

   task automatic t_continuous;
      int first, second, v1, v2;
      first = 0; second = 0;
      wr(A_LO, 3); wr(A_HI, 0);
      wr(CA, 8'h01);
      for (int k = 1; k <= 10 && first == 0; k++) begin
         @(negedge clk);
         if (uf_a_irq) first = k;
      end
      chk("R4 first underflow cycle", first, 4);
      for (int k = 1; k <= 10 && second == 0; k++) begin
         @(negedge clk);
         if (uf_a_irq) second = k;
      end
      chk("R12 one-cycle flag and R4 period", second, 4);
      wr(CA, 8'h00);
      rd(A_LO, v1); wait_cyc(6); rd(A_LO, v2);
      chk("R7 stopped counter holds", v2, v1);
   endtask

   task automatic t_hi_running;
      int v;
      wr(A_LO, 8'h80); wr(A_HI, 0);
      wr(CA, 8'h01);
      wr(A_HI, 8'h40);
      wr(CA, 8'h00);
      rd(A_HI, v); chk("R3 high write while running leaves counter", v, 0);
      wr(CA, 8'h10);
      rd(A_HI, v); chk("R6 strobe loads high", v, 8'h40);
      rd(A_LO, v); chk("R6 strobe loads low", v, 8'h80);
      rd(CA, v);   chk("R6 strobe reads back 0", v, 0);
      wr(A_LO, 8'h11);
      wr(CA, 8'h00);
      rd(A_LO, v); chk("R6 strobe 0 has no effect", v, 8'h80);
   endtask

   task automatic t_oneshot;
      int v, b;
      wr(A_LO, 2); wr(A_HI, 0);
      b = na;
      wr(CA, 8'h09);
      wait_cyc(20);
      chk("R5 single underflow", na - b, 1);
      rd(CA, v); chk("R5 run bit cleared", v, 8'h08);
      rd(A_LO, v); chk("R5 counter at latch", v, 2);
   endtask

   task automatic t_pulse_pin;
      int highs, dbl, prev;
      highs = 0; dbl = 0; prev = 0;
      wr(A_LO, 3); wr(A_HI, 0);
      wr(CA, 8'h03);
      chk("R10 pin enable", int'(pa_pin_en), 1);
      for (int k = 1; k <= 40; k++) begin
         @(negedge clk);
         if (pa_pin) highs++;
         if (pa_pin && prev != 0) dbl++;
         prev = int'(pa_pin);
      end
      chk("R10 pulse count", highs, 10);
      chk("R10 pulse width one cycle", dbl, 0);
      wr(CA, 8'h00);
      chk("R10 pin enable off", int'(pa_pin_en), 0);
   endtask

   task automatic t_toggle;
      int p0;
      wr(A_LO, 3); wr(A_HI, 0);
      wr(CA, 8'h05);
      p0 = int'(pa_pin);
      wait_cyc(3);
      chk("R11 pin before underflow", int'(pa_pin), p0);
      wait_cyc(1);
      chk("R11 pin after first underflow", int'(pa_pin), p0 ^ 1);
      wait_cyc(4);
      chk("R11 pin after second underflow", int'(pa_pin), p0);
      wr(CA, 8'h00);
   endtask

   task automatic t_cnt_a;
      int b, v1, v2;
      wr(A_LO, 2); wr(A_HI, 0);
      wr(CA, 8'h21);
      b = na;
      cnt_pulses(2); wait_cyc(4);
      chk("R8 no underflow after 2 edges", na - b, 0);
      cnt_pulses(1); wait_cyc(4);
      chk("R8 underflow after 3 edges", na - b, 1);
      rd(A_LO, v1); wait_cyc(20); rd(A_LO, v2);
      chk("R8 no clock counting in edge mode", v2, v1);
      wr(CA, 8'h00);
   endtask

   task automatic t_b_sources;
      int first, b, ba;
      // 00: clock cycles
      first = 0;
      wr(B_LO, 4); wr(B_HI, 0);
      wr(CB, 8'h03);
      chk("R10 B pin enable", int'(pb_pin_en), 1);
      for (int k = 1; k <= 10 && first == 0; k++) begin
         @(negedge clk);
         if (uf_b_irq) first = k;
      end
      chk("R9 B clock source first underflow", first, 5);
      wr(CB, 8'h00);
      // 01: count-input edges
      wr(B_LO, 1); wr(B_HI, 0);
      wr(CB, 8'h21);
      b = nb;
      cnt_pulses(4); wait_cyc(4);
      chk("R9 B edge source", nb - b, 2);
      wr(CB, 8'h00);
      // 10: timer A underflows
      wr(A_LO, 1); wr(A_HI, 0);
      wr(B_LO, 2); wr(B_HI, 0);
      wr(CB, 8'h41);
      b = nb; ba = na;
      wr(CA, 8'h01);
      for (int i = 0; i < 400 && (na - ba) < 30; i++) @(negedge clk);
      chk("R9 B chained on A", nb - b, 10);
      wr(CA, 8'h00); wr(CB, 8'h00);
      // 11: A underflows gated by count input level
      wr(A_HI, 0); wr(B_HI, 0);
      wr(CB, 8'h61);
      b = nb; ba = na;
      wr(CA, 8'h01);
      for (int i = 0; i < 400 && (na - ba) < 20; i++) @(negedge clk);
      chk("R9 B gated off while input low", nb - b, 0);
      wr(CA, 8'h00);
      wr(A_HI, 0);
      cnt_in = 1'b1; wait_cyc(5);
      b = nb; ba = na;
      wr(CA, 8'h01);
      for (int i = 0; i < 400 && (na - ba) < 30; i++) @(negedge clk);
      chk("R9 B gated on while input high", nb - b, 10);
      wr(CA, 8'h00); wr(CB, 8'h00);
      cnt_in = 1'b0;
   endtask

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      t_reset();
      t_latch_load();
      t_continuous();
      t_hi_running();
      t_oneshot();
      t_pulse_pin();
      t_toggle();
      t_cnt_a();
      t_b_sources();
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule